// File: doc/BRIEF.md
# SD Host Register Compatibility Shim

This block connects a host bus that expects the standard SD host controller register map, with its byte, halfword and word registers, to a register file in which every register is one 32-bit word and a few fields sit at other bit positions. Every host request is served by fetching the containing word from the register file. A read then returns the correct byte or halfword lane, with relocated fields moved back to their standard positions. A write merges the new value into the fetched word, applies the field fixups, and stores the whole word back.

Writes to the 16-bit transfer-mode register are held in a shadow register inside the shim. They reach the register file only together with the next command-register write, so both halves of that word land in one store.

Requests use a valid/ready handshake. `req_ready` is high only while the shim is idle. A request is accepted on a clock edge at which `req_valid` and `req_ready` are both high. After acceptance `req_ready` stays low until the transaction has finished. The host must hold the request fields stable while `req_valid` is high and `req_ready` is low. Read results are returned as a one-cycle `rsp_valid` pulse with no back-pressure, so the host must be able to take a response at any time.

Top module: `sdreg_shim`

## Requirements
- R1: Reads fetch the word at address & ~3. A 16-bit read (req_size=1) returns bits [16*addr[1] +: 16], a byte read (req_size=0) returns bits [8*addr[1:0] +: 8], zero-extended to 32 bits. Word reads (req_size=2) of unremapped offsets return the word unchanged.
- R2: A word read at offset 0x24 returns backing bits 19:0 unchanged, backing bits 27:24 in result bits 23:20, backing bit 23 in result bit 24, and zeros in bits 31:25.
- R3: A word read at offset 0x40 with backing bit 20 set also reports bit 19 set when the parameter VENDOR_VER exceeds 8'h12 (default 8'h13). With bit 20 clear, the word is returned unchanged.
- R4: A 16-bit write at offset 0x0C only updates the shadow register and causes no register-file write.
- R5: A 16-bit write at offset 0x0E stores {write value, shadow} into word 0x0C in a single register-file write.
- R6: A 16-bit write at offset 0x04 clears word bits 14:12 after merging. Other halfword writes replace only their own lane.
- R7: A byte write at offset 0x29 causes no register-file write.
- R8: A byte write at offset 0x28 puts value bits 4:3 into word bits 9:8, keeps the old word bits 4:3 and bits 31:10, takes the other low-byte bits from the value, and forces bit 2 to zero.
- R9: A byte read at offset 0x28 returns word bits 7:0 with bits 4:3 replaced by word bits 9:8.
- R10: A word write at offset 0x34 stores the value with bit 2 forced to one. Word writes to other offsets store the value as given.
- R11: After reset `req_ready` is 1 and `rsp_valid` and `be_wr_en` are 0. After a request is accepted, `req_ready` is 0 until the transaction completes. The read response is valid in the cycle after the fetch cycle, which is one clock edge after the accepting edge.
- R12: The shadow register resets to zero, so a command write before any transfer-mode write stores zeros in the low half.
- R13: Byte writes to other offsets replace only their own byte lane of the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Shim can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address in the standard map |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data, zero-extended |
| be_addr | output | ADDR_W-2 | Register-file word address |
| be_rd_en | output | 1 | Register-file read strobe (fetch cycle) |
| be_rdata | input | 32 | Register-file read data, same cycle as be_addr |
| be_wr_en | output | 1 | Register-file write strobe |
| be_wdata | output | 32 | Register-file write word |

## Verification
When a request is accepted at edge E0, the shim fetches the word during the cycle that ends at E1. `rsp_valid` is then high in the cycle between E1 and E2, and any register-file write is committed at E2, after which `req_ready` rises again. The scoreboard monitor samples on falling edges and checks that each response arrives exactly one cycle count after the one recorded at acceptance. Write effects are checked on the bench's register-file model, and the count of register-file writes is checked at the falling edge after `req_ready` returns. Each check therefore sees a completed transaction and never races one still in progress.

// File: rtl/sdshim_pkg.sv
package sdshim_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  localparam int unsigned OFF_BLKSZ  = 8'h04;
  localparam int unsigned OFF_TXMODE = 8'h0C;
  localparam int unsigned OFF_CMD    = 8'h0E;
  localparam int unsigned OFF_PSTATE = 8'h24;
  localparam int unsigned OFF_HCTL   = 8'h28;
  localparam int unsigned OFF_PWR    = 8'h29;
  localparam int unsigned OFF_IEN    = 8'h34;
  localparam int unsigned OFF_CAPS   = 8'h40;

  localparam int unsigned CAP_ADMA1_BIT = 20;
  localparam int unsigned CAP_ADMA2_BIT = 19;
  localparam int unsigned IEN_GAP_BIT   = 2;
  localparam logic [31:0] BLK_BOUND_MASK = 32'h0000_7000;
  localparam logic [7:0]  HCTL_RSVD_MASK = 8'h04;
endpackage

// File: rtl/sdshim_rd_fix.sv
module sdshim_rd_fix
  import sdshim_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  VENDOR_VER = 8'h13
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       word,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W-1:0] A_PSTATE = ADDR_W'(OFF_PSTATE);
  localparam logic [ADDR_W-1:0] A_CAPS   = ADDR_W'(OFF_CAPS);
  localparam logic [ADDR_W-1:0] A_HCTL   = ADDR_W'(OFF_HCTL);

  logic [31:0] caps_fix;
  logic [31:0] lane_h;
  logic [31:0] lane_b;
  logic [7:0]  byte_v;

  generate
    if (VENDOR_VER > 8'h12) begin : g_adma2_promote
      always_comb begin
        caps_fix = word;
        if (word[CAP_ADMA1_BIT]) caps_fix[CAP_ADMA2_BIT] = 1'b1;
      end
    end else begin : g_adma2_plain
      assign caps_fix = word;
    end
  endgenerate

  always_comb begin
    lane_h = word >> {addr[1], 4'b0000};
    lane_b = word >> {addr[1:0], 3'b000};
    byte_v = lane_b[7:0];
    if (addr == A_HCTL) byte_v[4:3] = word[9:8];
    unique case (acc_size_e'(size))
      SZ_WORD: begin
        if (addr == A_PSTATE)
          rdata = {7'b0, word[23], word[27:24], word[19:0]};
        else if (addr == A_CAPS)
          rdata = caps_fix;
        else
          rdata = word;
      end
      SZ_HALF: rdata = {16'b0, lane_h[15:0]};
      default: rdata = {24'b0, byte_v};
    endcase
  end
endmodule

// File: rtl/sdshim_wr_fix.sv
module sdshim_wr_fix
  import sdshim_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [31:0]       old_word,
  input  logic [15:0]       shadow,
  output logic [31:0]       new_word,
  output logic              suppress,
  output logic              tm_capture
);
  localparam logic [ADDR_W-1:0] A_BLKSZ  = ADDR_W'(OFF_BLKSZ);
  localparam logic [ADDR_W-1:0] A_TXMODE = ADDR_W'(OFF_TXMODE);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_HCTL   = ADDR_W'(OFF_HCTL);
  localparam logic [ADDR_W-1:0] A_PWR    = ADDR_W'(OFF_PWR);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFF_IEN);

  logic [31:0] half_mask, byte_mask;
  logic [31:0] half_ins, byte_ins;
  logic [31:0] hctl_word;

  always_comb begin
    half_mask = 32'h0000_FFFF << {addr[1], 4'b0000};
    half_ins  = {16'b0, wdata[15:0]} << {addr[1], 4'b0000};
    byte_mask = 32'h0000_00FF << {addr[1:0], 3'b000};
    byte_ins  = {24'b0, wdata[7:0]} << {addr[1:0], 3'b000};

    hctl_word      = old_word;
    hctl_word[9:8] = wdata[4:3];
    hctl_word[7:0] = {wdata[7:5], old_word[4:3], wdata[2:0]} & ~HCTL_RSVD_MASK;

    suppress   = 1'b0;
    tm_capture = 1'b0;
    unique case (acc_size_e'(size))
      SZ_WORD: begin
        new_word = wdata;
        if (addr == A_IEN) new_word[IEN_GAP_BIT] = 1'b1;
      end
      SZ_HALF: begin
        if (addr == A_TXMODE) begin
          suppress   = 1'b1;
          tm_capture = 1'b1;
          new_word   = old_word;
        end else if (addr == A_CMD) begin
          new_word = {wdata[15:0], shadow};
        end else begin
          new_word = (old_word & ~half_mask) | half_ins;
          if (addr == A_BLKSZ) new_word = new_word & ~BLK_BOUND_MASK;
        end
      end
      default: begin
        if (addr == A_PWR) begin
          suppress = 1'b1;
          new_word = old_word;
        end else if (addr == A_HCTL) begin
          new_word = hctl_word;
        end else begin
          new_word = (old_word & ~byte_mask) | byte_ins;
        end
      end
    endcase
  end
endmodule

// File: rtl/sdshim_ctl.sv
module sdshim_ctl #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       be_rdata,
  input  logic [31:0]       new_word,
  input  logic              suppress,
  input  logic              tm_capture,
  output logic              q_write,
  output logic [1:0]        q_size,
  output logic [ADDR_W-1:0] q_addr,
  output logic [31:0]       q_wdata,
  output logic [31:0]       old_q,
  output logic [15:0]       shadow_q,
  output logic [ADDR_W-3:0] be_addr,
  output logic              be_rd_en,
  output logic              be_wr_en,
  output logic [31:0]       be_wdata,
  output logic              rsp_valid
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} state_e;
  state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      q_write  <= 1'b0;
      q_size   <= 2'd0;
      q_addr   <= '0;
      q_wdata  <= '0;
      old_q    <= '0;
      shadow_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_size  <= req_size;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          state   <= ST_FETCH;
        end
        ST_FETCH: begin
          old_q <= be_rdata;
          state <= ST_EXEC;
        end
        default: begin
          if (q_write && tm_capture) shadow_q <= q_wdata[15:0];
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign be_rd_en  = (state == ST_FETCH);
  assign be_addr   = q_addr[ADDR_W-1:2];
  assign be_wr_en  = (state == ST_EXEC) && q_write && !suppress;
  assign be_wdata  = new_word;
  assign rsp_valid = (state == ST_EXEC) && !q_write;

  AST_RSP_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(be_rd_en)); // R11
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11
endmodule

// File: rtl/sdreg_shim.sv
module sdreg_shim
  import sdshim_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  VENDOR_VER = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [ADDR_W-3:0] be_addr,
  output logic              be_rd_en,
  input  logic [31:0]       be_rdata,
  output logic              be_wr_en,
  output logic [31:0]       be_wdata
);
  localparam logic [ADDR_W-1:0] A_BLKSZ  = ADDR_W'(OFF_BLKSZ);
  localparam logic [ADDR_W-1:0] A_TXMODE = ADDR_W'(OFF_TXMODE);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_HCTL   = ADDR_W'(OFF_HCTL);
  localparam logic [ADDR_W-1:0] A_PWR    = ADDR_W'(OFF_PWR);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFF_IEN);

  logic              q_write;
  logic [1:0]        q_size;
  logic [ADDR_W-1:0] q_addr;
  logic [31:0]       q_wdata;
  logic [31:0]       old_q;
  logic [15:0]       shadow_q;
  logic [31:0]       new_word;
  logic              suppress;
  logic              tm_capture;

  sdshim_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .be_rdata(be_rdata), .new_word(new_word), .suppress(suppress),
    .tm_capture(tm_capture), .q_write(q_write), .q_size(q_size),
    .q_addr(q_addr), .q_wdata(q_wdata), .old_q(old_q), .shadow_q(shadow_q),
    .be_addr(be_addr), .be_rd_en(be_rd_en), .be_wr_en(be_wr_en),
    .be_wdata(be_wdata), .rsp_valid(rsp_valid)
  );

  sdshim_rd_fix #(.ADDR_W(ADDR_W), .VENDOR_VER(VENDOR_VER)) u_rd (
    .size(q_size), .addr(q_addr), .word(old_q), .rdata(rsp_rdata)
  );

  sdshim_wr_fix #(.ADDR_W(ADDR_W)) u_wr (
    .size(q_size), .addr(q_addr), .wdata(q_wdata), .old_word(old_q),
    .shadow(shadow_q), .new_word(new_word), .suppress(suppress),
    .tm_capture(tm_capture)
  );

  logic is_half, is_byte, is_word;
  assign is_half = (q_size == 2'd1);
  assign is_byte = (q_size == 2'd0);
  assign is_word = (q_size == 2'd2);

  AST_TM_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    be_wr_en |-> !(is_half && q_addr == A_TXMODE)); // R4
  AST_CMD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (be_wr_en && is_half && q_addr == A_CMD) |-> be_wdata[15:0] == shadow_q); // R5
  AST_BLK_BOUND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (be_wr_en && is_half && q_addr == A_BLKSZ) |-> be_wdata[14:12] == 3'b000); // R6
  AST_PWR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(be_rd_en) && q_write && is_byte && q_addr == A_PWR) |-> !be_wr_en); // R7
  AST_HCTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (be_wr_en && is_byte && q_addr == A_HCTL) |-> !be_wdata[2]); // R8
  AST_IEN_GAP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (be_wr_en && is_word && q_addr == A_IEN) |-> be_wdata[2]); // R10
endmodule

// File: tb/sdreg_shim_tb_top.sv
module sdreg_shim_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        req_ready, rsp_valid, be_rd_en, be_wr_en;
  logic [31:0] rsp_rdata, be_wdata, be_rdata;
  logic [5:0]  be_addr;

  sdreg_shim dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .be_addr(be_addr), .be_rd_en(be_rd_en), .be_rdata(be_rdata),
    .be_wr_en(be_wr_en), .be_wdata(be_wdata)
  );

  logic [31:0] mem [64];
  int wr_count = 0;
  assign be_rdata = mem[be_addr];
  always @(posedge clk) if (be_wr_en) begin
    mem[be_addr] <= be_wdata;
    wr_count <= wr_count + 1;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int acc_cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) chk(0, "R1 unexpected response", rsp_rdata, 32'h0);
    else begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(rsp_rdata === e, t, rsp_rdata, e);
      chk(cyc == acc_cyc + 1, {"R11 latency ", t}, cyc - acc_cyc, 1);
    end
  end

  task automatic do_req(input logic w, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc_cyc = cyc;
    chk(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    do_req(1'b0, sz, a, 32'h0);
  endtask

  function automatic logic [31:0] pstate_exp(input logic [31:0] v);
    logic [31:0] r = 32'h0;
    r[19:0]  = v[19:0];
    r[23:20] = v[27:24];
    r[24]    = v[23];
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int wc;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[8'h20 >> 2] = 32'hCAFE_F00D;
    mem[8'h24 >> 2] = 32'hA5A5_A5A5;
    mem[8'h40 >> 2] = 32'h0010_0000;
    mem[8'h0C >> 2] = 32'hDEAD_BEEF;
    mem[8'h04 >> 2] = 32'hAAAA_0000;
    mem[8'h30 >> 2] = 32'h1122_3344;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && !be_wr_en, "R11 reset state", {req_ready, rsp_valid, be_wr_en}, 3'b100);
    rst_n = 1'b1;

    rd(2'd2, 8'h20, 32'hCAFE_F00D, "R1 word read");
    rd(2'd1, 8'h20, 32'h0000_F00D, "R1 half low");
    rd(2'd1, 8'h22, 32'h0000_CAFE, "R1 half high");
    rd(2'd0, 8'h21, 32'h0000_00F0, "R1 byte 1");
    rd(2'd0, 8'h23, 32'h0000_00CA, "R1 byte 3");

    rd(2'd2, 8'h24, pstate_exp(32'hA5A5_A5A5), "R2 pstate a");
    mem[8'h24 >> 2] = 32'h0F80_0000;
    rd(2'd2, 8'h24, pstate_exp(32'h0F80_0000), "R2 pstate b");

    rd(2'd2, 8'h40, 32'h0018_0000, "R3 adma2 promoted");
    mem[8'h40 >> 2] = 32'h0000_0123;
    rd(2'd2, 8'h40, 32'h0000_0123, "R3 caps unchanged");

    do_req(1'b1, 2'd1, 8'h0E, 32'h1234);
    @(negedge clk);
    chk(mem[3] == 32'h1234_0000, "R12 shadow reset zero", mem[3], 32'h1234_0000);

    wc = wr_count;
    do_req(1'b1, 2'd1, 8'h0C, 32'h0055);
    @(negedge clk);
    chk(wr_count == wc, "R4 no store count", wr_count, wc);
    chk(mem[3] == 32'h1234_0000, "R4 word unchanged", mem[3], 32'h1234_0000);
    do_req(1'b1, 2'd1, 8'h0E, 32'h3A1B);
    @(negedge clk);
    chk(mem[3] == 32'h3A1B_0055, "R5 merged command", mem[3], 32'h3A1B_0055);
    chk(wr_count == wc + 1, "R5 single store", wr_count, wc + 1);

    do_req(1'b1, 2'd1, 8'h04, 32'hF200);
    @(negedge clk);
    chk(mem[1] == 32'hAAAA_8200, "R6 boundary cleared", mem[1], 32'hAAAA_8200);
    do_req(1'b1, 2'd1, 8'h06, 32'h7777);
    @(negedge clk);
    chk(mem[1] == 32'h7777_8200, "R6 other lane", mem[1], 32'h7777_8200);

    do_req(1'b1, 2'd0, 8'h28, 32'hFF);
    @(negedge clk);
    chk(mem[10] == 32'h0000_03E3, "R8 hctl write a", mem[10], 32'h0000_03E3);
    rd(2'd0, 8'h28, 32'h0000_00FB, "R9 hctl read a");
    wc = wr_count;
    do_req(1'b1, 2'd0, 8'h29, 32'h0F);
    @(negedge clk);
    chk(wr_count == wc, "R7 power no store", wr_count, wc);
    chk(mem[10] == 32'h0000_03E3, "R7 power word kept", mem[10], 32'h0000_03E3);
    do_req(1'b1, 2'd0, 8'h28, 32'h08);
    @(negedge clk);
    chk(mem[10] == 32'h0000_0100, "R8 hctl write b", mem[10], 32'h0000_0100);
    rd(2'd0, 8'h28, 32'h0000_0008, "R9 hctl read b");

    do_req(1'b1, 2'd2, 8'h34, 32'h0);
    @(negedge clk);
    chk(mem[13] == 32'h0000_0004, "R10 gap forced a", mem[13], 32'h0000_0004);
    do_req(1'b1, 2'd2, 8'h34, 32'hFFFF_0001);
    @(negedge clk);
    chk(mem[13] == 32'hFFFF_0005, "R10 gap forced b", mem[13], 32'hFFFF_0005);
    do_req(1'b1, 2'd2, 8'h38, 32'h0000_0000);
    @(negedge clk);
    chk(mem[14] == 32'h0, "R10 plain word write", mem[14], 32'h0);

    do_req(1'b1, 2'd0, 8'h32, 32'h5A);
    @(negedge clk);
    chk(mem[12] == 32'h115A_3344, "R13 byte lane merge", mem[12], 32'h115A_3344);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 responses drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule